// File: doc/BRIEF.md
# UART Interrupt Identification and Status

This block gathers every interrupt condition of a UART and turns it into one status byte that the host reads. Four standard conditions arrive as levels from their owner blocks: receive line status, receive data, transmit empty and modem status. Each level stays asserted until its owner clears it. Three enhanced conditions are latched here and need enhanced mode. Two of them share one bit: a received Xoff character and a received special character. The third is a rising edge on either flow-control line. Each enhanced condition has its own clear rule.

The status byte has these fields:

- An active-low "nothing pending" flag in bit 0.
- A 3-bit code in bits 3:1 naming the highest-priority pending source.
- Two enhanced-source flag bits in bits 5:4.
- Two copies of the FIFO-enable level in bits 7:6.

A clear caused by a host read takes effect when the read strobe falls, so the byte does not change under the host while the access is in progress. The interrupt output is the inverse of bit 0. The block has no serializers, baud logic or address decoding; it only latches, ranks and clears conditions.

Top module: `uart_irq_status`

## Requirements
- R1: After reset the status byte reads 8'h01 and `irq_out` is 0.
- R2: Bit 0 is 0 exactly when at least one source is pending, and `irq_out` is always the inverse of bit 0.
- R3: Bits 3:1 hold the code of the highest-ranked pending source. Ranks and codes, highest first: line status 3'b011, receive data 3'b010, transmit empty 3'b001, modem 3'b000, Xoff/special 3'b100, flow-line change 3'b101. With nothing pending, bits 3:1 are 3'b000.
- R4: Bits 7 and 6 both equal `fifo_on`.
- R5: With `enh_en` at 1, an `xoff_hit` pulse sets bit 4. A completed status read clears it, where completion is the falling edge of `stat_rd`.
- R6: A pending Xoff condition is also cleared by an `xon_hit` pulse.
- R7: With `enh_en` at 1, a `spec_hit` pulse sets bit 4. The next `rx_char` pulse without `spec_hit` clears it. A status read does not clear it. When `spec_hit` and `rx_char` occur in the same cycle, the condition is set.
- R8: With `enh_en` at 1, a 0-to-1 change on `cts_line` or `rts_line` sets bit 5. A completed status read clears it. A 1-to-0 change has no effect.
- R9: While `enh_en` is 0, all three enhanced conditions are held clear, and enhanced events have no effect.
- R10: While `stat_rd` is held at 1, no read-cleared condition is cleared. When a set event and a clear event hit the same condition in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rls_lvl | input | 1 | Receive line status condition (level) |
| rxd_lvl | input | 1 | Receive data condition (level) |
| thr_lvl | input | 1 | Transmit empty condition (level) |
| msr_lvl | input | 1 | Modem status condition (level) |
| enh_en | input | 1 | Enhanced features enable |
| fifo_on | input | 1 | FIFOs enabled level |
| rx_char | input | 1 | One-cycle pulse per received character |
| xoff_hit | input | 1 | Pulse: received Xoff character matched |
| spec_hit | input | 1 | Pulse: received special character matched |
| xon_hit | input | 1 | Pulse: received Xon character matched |
| cts_line | input | 1 | Clear-to-send line level |
| rts_line | input | 1 | Request-to-send line level |
| stat_rd | input | 1 | Host read strobe for the status byte, high during the access |
| stat_byte | output | 8 | Registered status byte |
| irq_out | output | 1 | Interrupt request, high when a source is pending |

## Verification
Every field of the status byte is registered once. A level change, an event pulse or a strobe fall seen at one rising edge therefore shows in `stat_byte` one clock later, and it is sampled at the following falling edge. The bench's behavioural model takes the inputs at each rising edge and computes the byte expected after that edge. That byte is compared field by field at the next falling edge. The directed checks wait exactly one clock after each stimulus before they sample, and they also check cycles where the strobe is still held, to confirm that nothing clears early.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NSRC   = 6;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        CODE_MSR  = 3'b000,
        CODE_THR  = 3'b001,
        CODE_RXD  = 3'b010,
        CODE_RLS  = 3'b011,
        CODE_CHAR = 3'b100,
        CODE_FLOW = 3'b101
    } irq_code_e;

    // index 0 is highest rank
    function automatic irq_code_e code_of(input int unsigned idx);
        case (idx)
            0:       return CODE_RLS;
            1:       return CODE_RXD;
            2:       return CODE_THR;
            3:       return CODE_MSR;
            4:       return CODE_CHAR;
            default: return CODE_FLOW;
        endcase
    endfunction

    typedef struct packed {
        logic xoff;
        logic spec;
        logic flow;
    } enh_flags_t;

    typedef struct packed {
        logic [1:0]        fifo_on;
        logic              flow_chg;
        logic              char_hit;
        logic [CODE_W-1:0] src;
        logic              none;
    } status_t;

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int         W       = 1,
    parameter bit         RISE    = 1'b1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] evt
);

    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= prev_d;
    end

    generate
        if (RISE) begin : g_rise
            assign evt = sig & ~prev_q;
        end else begin : g_fall
            assign evt = ~sig & prev_q;
        end
    endgenerate

endmodule

// File: rtl/irq_enh_flags.sv
module irq_enh_flags
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enh_en,
    input  logic       xoff_hit,
    input  logic       spec_hit,
    input  logic       xon_hit,
    input  logic       rx_char,
    input  logic       rd_done,
    input  logic       flow_rise,
    output enh_flags_t flags_d,
    output enh_flags_t flags_q
);

    always_comb begin
        flags_d = flags_q;
        if (!enh_en) begin
            flags_d = '0;
        end else begin
            if (xoff_hit)                flags_d.xoff = 1'b1;
            else if (xon_hit || rd_done) flags_d.xoff = 1'b0;

            if (spec_hit)     flags_d.spec = 1'b1;
            else if (rx_char) flags_d.spec = 1'b0;

            if (flow_rise)    flags_d.flow = 1'b1;
            else if (rd_done) flags_d.flow = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    AST_XOFF_RD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (enh_en && rd_done && !xoff_hit) |=> !flags_q.xoff); // R5
    AST_XON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (enh_en && xon_hit && !xoff_hit) |=> !flags_q.xoff); // R6
    AST_SPEC_NEXT_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        (enh_en && rx_char && !spec_hit) |=> !flags_q.spec); // R7
    AST_FLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (enh_en && flow_rise) |=> flags_q.flow); // R8
    AST_ENH_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_en |=> (flags_q == '0)); // R9

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import uart_irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0]      req,
    output logic              any,
    output logic [CODE_W-1:0] code
);

    always_comb begin
        code = CODE_MSR;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) code = code_of(i);
        end
        any = |req;
    end

    always_comb begin
        AST_IDLE_ZERO_CODE: assert (any || code == 3'b000); // R3
    end

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rls_lvl,
    input  logic       rxd_lvl,
    input  logic       thr_lvl,
    input  logic       msr_lvl,
    input  logic       enh_en,
    input  logic       fifo_on,
    input  logic       rx_char,
    input  logic       xoff_hit,
    input  logic       spec_hit,
    input  logic       xon_hit,
    input  logic       cts_line,
    input  logic       rts_line,
    input  logic       stat_rd,
    output logic [7:0] stat_byte,
    output logic       irq_out
);

    localparam int NLINE = 2;

    logic             rd_done;
    logic [NLINE-1:0] line_rise;
    enh_flags_t       flags_d, flags_q;
    logic [NSRC-1:0]  req;
    logic             any_req;
    logic [CODE_W-1:0] top_code;
    status_t          stat_d, stat_q;

    irq_edge_det #(.W(1), .RISE(1'b0), .RST_VAL(1'b0)) u_rd_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (stat_rd),
        .evt  (rd_done)
    );

    irq_edge_det #(.W(NLINE), .RISE(1'b1), .RST_VAL({NLINE{1'b1}})) u_line_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  ({rts_line, cts_line}),
        .evt  (line_rise)
    );

    irq_enh_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .enh_en   (enh_en),
        .xoff_hit (xoff_hit),
        .spec_hit (spec_hit),
        .xon_hit  (xon_hit),
        .rx_char  (rx_char),
        .rd_done  (rd_done),
        .flow_rise(|line_rise),
        .flags_d  (flags_d),
        .flags_q  (flags_q)
    );

    always_comb begin
        req = {flags_d.flow, flags_d.xoff | flags_d.spec,
               msr_lvl, thr_lvl, rxd_lvl, rls_lvl};
    end

    irq_prio_enc #(.N(NSRC)) u_enc (
        .req (req),
        .any (any_req),
        .code(top_code)
    );

    always_comb begin
        stat_d          = stat_q;
        stat_d.fifo_on  = {2{fifo_on}};
        stat_d.flow_chg = flags_d.flow;
        stat_d.char_hit = flags_d.xoff | flags_d.spec;
        stat_d.src      = top_code;
        stat_d.none     = ~any_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '{fifo_on: 2'b00, flow_chg: 1'b0, char_hit: 1'b0,
                                src: 3'b000, none: 1'b1};
        else        stat_q <= stat_d;
    end

    assign stat_byte = stat_q;
    assign irq_out   = ~stat_q.none;

    AST_FIFO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stat_byte[7:6] == {2{$past(fifo_on)}})); // R4
    AST_RLS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rls_lvl |=> (stat_byte[3:1] == 3'b011 && !stat_byte[0])); // R3
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && enh_en && flags_q.xoff && !xon_hit) |=> stat_byte[4]); // R10
    AST_IRQ_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_lvl || thr_lvl) |=> irq_out); // R2

endmodule

// File: tb/uart_irq_status_test.sv
module uart_irq_status_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rls_lvl = 0, rxd_lvl = 0, thr_lvl = 0, msr_lvl = 0;
    logic enh_en = 0, fifo_on = 0, rx_char = 0, xoff_hit = 0, spec_hit = 0, xon_hit = 0;
    logic cts_line = 0, rts_line = 0, stat_rd = 0;
    logic [7:0] stat_byte;
    logic       irq_out;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    uart_irq_status uut (
        .clk(clk), .rst_n(rst_n),
        .rls_lvl(rls_lvl), .rxd_lvl(rxd_lvl), .thr_lvl(thr_lvl), .msr_lvl(msr_lvl),
        .enh_en(enh_en), .fifo_on(fifo_on), .rx_char(rx_char),
        .xoff_hit(xoff_hit), .spec_hit(spec_hit), .xon_hit(xon_hit),
        .cts_line(cts_line), .rts_line(rts_line), .stat_rd(stat_rd),
        .stat_byte(stat_byte), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_xoff = 0, m_spec = 0, m_flow = 0;
    bit m_rd_was = 0, m_cts_was = 1, m_rts_was = 1;
    logic [7:0] m_stat = 8'h01;

    always @(posedge clk) begin
        bit rd_end, rise;
        bit [3:0] code;
        bit pend;
        if (!rst_n) begin
            m_xoff = 0; m_spec = 0; m_flow = 0;
            m_rd_was = 0; m_cts_was = 1; m_rts_was = 1;
            m_stat = 8'h01;
        end else begin
            rd_end = m_rd_was && !stat_rd;
            rise   = (cts_line && !m_cts_was) || (rts_line && !m_rts_was);
            if (!enh_en) begin
                m_xoff = 0; m_spec = 0; m_flow = 0;
            end else begin
                if (xoff_hit) m_xoff = 1; else if (xon_hit || rd_end) m_xoff = 0;
                if (spec_hit) m_spec = 1; else if (rx_char) m_spec = 0;
                if (rise) m_flow = 1; else if (rd_end) m_flow = 0;
            end
            m_rd_was = stat_rd; m_cts_was = cts_line; m_rts_was = rts_line;
            pend = 1;
            if (rls_lvl) code = 3;
            else if (rxd_lvl) code = 2;
            else if (thr_lvl) code = 1;
            else if (msr_lvl) code = 0;
            else if (m_xoff || m_spec) code = 4;
            else if (m_flow) code = 5;
            else begin code = 0; pend = 0; end
            m_stat = {fifo_on, fifo_on, m_flow, m_xoff || m_spec, code[2:0], !pend};
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            chk("R2 bit0",   {7'd0, stat_byte[0]},   {7'd0, m_stat[0]});
            chk("R2 irq",    {7'd0, irq_out},        {7'd0, ~m_stat[0]});
            chk("R3 code",   {5'd0, stat_byte[3:1]}, {5'd0, m_stat[3:1]});
            chk("R4 fifo",   {6'd0, stat_byte[7:6]}, {6'd0, m_stat[7:6]});
            chk("R5 R7 b4",  {7'd0, stat_byte[4]},   {7'd0, m_stat[4]});
            chk("R8 b5",     {7'd0, stat_byte[5]},   {7'd0, m_stat[5]});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog got=%0d exp=<20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick(); @(negedge clk); endtask

    initial begin
        repeat (3) tick();
        chk("R1 reset byte", stat_byte, 8'h01);
        chk("R1 reset irq", {7'd0, irq_out}, 8'h00);
        rst_n = 1'b1;
        tick();

        // R3 ranking of level sources
        msr_lvl = 1; tick(); chk("R3 msr", stat_byte, 8'h00);
        thr_lvl = 1; tick(); chk("R3 thr", stat_byte, 8'h02);
        rxd_lvl = 1; tick(); chk("R3 rxd", stat_byte, 8'h04);
        rls_lvl = 1; tick(); chk("R3 rls", stat_byte, 8'h06);
        chk("R2 irq high", {7'd0, irq_out}, 8'h01);
        rls_lvl = 0; rxd_lvl = 0; thr_lvl = 0; msr_lvl = 0; tick();
        chk("R2 idle", stat_byte, 8'h01);

        // R4
        fifo_on = 1; tick(); chk("R4 fifo on", stat_byte, 8'hC1);
        fifo_on = 0; tick(); chk("R4 fifo off", stat_byte, 8'h01);

        // R5 and R10
        enh_en = 1; tick();
        xoff_hit = 1; tick(); xoff_hit = 0;
        chk("R5 xoff set", stat_byte, 8'h18);
        stat_rd = 1; tick(); chk("R10 held", stat_byte, 8'h18);
        tick(); chk("R10 still held", stat_byte, 8'h18);
        stat_rd = 0; tick(); chk("R5 read clear", stat_byte, 8'h01);

        // R6
        xoff_hit = 1; tick(); xoff_hit = 0; chk("R6 set", stat_byte, 8'h18);
        xon_hit = 1; tick(); xon_hit = 0; chk("R6 xon clear", stat_byte, 8'h01);

        // R10 set wins over read clear
        xoff_hit = 1; tick(); xoff_hit = 0;
        stat_rd = 1; tick();
        stat_rd = 0; xoff_hit = 1; tick(); xoff_hit = 0;
        chk("R10 set wins", stat_byte, 8'h18);
        xon_hit = 1; tick(); xon_hit = 0;

        // R7
        spec_hit = 1; rx_char = 1; tick(); spec_hit = 0; rx_char = 0;
        chk("R7 set with char", stat_byte, 8'h18);
        stat_rd = 1; tick(); stat_rd = 0; tick();
        chk("R7 read ignored", stat_byte, 8'h18);
        rx_char = 1; tick(); rx_char = 0;
        chk("R7 next char clear", stat_byte, 8'h01);

        // R8
        cts_line = 1; tick(); chk("R8 cts rise", stat_byte, 8'h2A);
        stat_rd = 1; tick(); stat_rd = 0; tick();
        chk("R8 read clear", stat_byte, 8'h01);
        cts_line = 0; tick(); chk("R8 fall ignored", stat_byte, 8'h01);
        rts_line = 1; tick(); chk("R8 rts rise", stat_byte, 8'h2A);
        xoff_hit = 1; tick(); xoff_hit = 0;
        chk("R3 char over flow", stat_byte, 8'h38);
        rls_lvl = 1; tick(); chk("R3 rls over enh", stat_byte, 8'h36);
        rls_lvl = 0;
        stat_rd = 1; tick(); stat_rd = 0; tick();
        chk("R5 R8 read clears both", stat_byte, 8'h01);
        rts_line = 0;

        // R9
        xoff_hit = 1; cts_line = 1; tick(); xoff_hit = 0;
        chk("R9 pre", stat_byte, 8'h38);
        enh_en = 0; tick(); chk("R9 drop clears", stat_byte, 8'h01);
        cts_line = 0; tick();
        xoff_hit = 1; spec_hit = 1; cts_line = 1; tick();
        xoff_hit = 0; spec_hit = 0;
        chk("R9 events ignored", stat_byte, 8'h01);
        enh_en = 1; tick(); chk("R9 no stale edge", stat_byte, 8'h01);

        repeat (3) tick();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule